// File: doc/BRIEF.md
# PPS-Aligned Synthesizer Sync Pulse Generator

This block drives one long, counted SYNC pulse toward an external clock-synthesizer chip, aligned to a pulse-per-second (PPS) timing reference. After the synthesizer has been configured, software first pulses the counter-clear control. It then raises the trigger control. A low-to-high transition of the trigger arms the block. The block then waits for the next rising edge of PPS and holds SYNC high for a counted number of clock cycles. The synthesizer uses that edge to line its outputs up with the reference.

PPS arrives asynchronously. It passes through a two-flop synchronizer and a rising-edge detector before it can start the pulse. The pulse length comes from the `pulse_len` input:
- A value of zero selects the default of 2 ms.
- A nonzero value below 1 ms is raised to 1 ms.
- Any other value is used as given.

The cycle counts are derived from the `CLK_HZ` parameter. The length is captured at the moment of arming. There is no data stream: every pin is a plain level-sensitive control or status signal.

Top module: `pps_sync_gen`

## Requirements
- R1: While `rst_n` is low, and after its release until the block is armed, `sync_out`, `busy` and `done` are all low. `sync_out` is never high while `busy` is low.
- R2: `busy` rises on the clock edge that first samples `trig` high after it was sampled low. A `trig` held high does not arm the block a second time.
- R3: Once armed, `sync_out` stays low until PPS rises. It goes high on the third rising clock edge that samples `pps_async` high: two synchronizer flops, then the edge register.
- R4: With `pulse_len` equal to 0, `sync_out` is high for exactly DEF_US microseconds, which is CLK_HZ*DEF_US/10^6 cycles. This is 2 ms by default.
- R5: With `pulse_len` nonzero but below MIN_US microseconds' worth of cycles (1 ms by default), the pulse lasts exactly that minimum.
- R6: With `pulse_len` at or above the minimum, the pulse lasts exactly `pulse_len` cycles. The value is sampled on the arming edge, and later changes do not affect that pulse.
- R7: Trigger edges that arrive while the block is armed or pulsing are ignored. After the pulse ends, the block stays idle until a fresh trigger edge arrives.
- R8: `done` is high for exactly one cycle: the first cycle in which `sync_out` is low after a pulse that ran to completion.
- R9: While `cnt_clr` is high, the armed state and any running pulse are cleared. On the next edge `sync_out`, `busy` and `done` are low. Trigger edges seen while `cnt_clr` is high are discarded.
- R10: PPS rising edges while the block is idle have no effect on `sync_out`, `busy` or `done`.
- R11: `busy` is high from the arming edge through the last high cycle of `sync_out`, and is low in the cycle that `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_clr | input | 1 | Active-high clear of the counter and the armed state |
| trig | input | 1 | Software trigger; its rising edge arms the block |
| pps_async | input | 1 | Asynchronous PPS reference |
| pulse_len | input | LEN_W | Requested pulse length in cycles; 0 selects the default |
| sync_out | output | 1 | SYNC pulse to the synthesizer |
| busy | output | 1 | High while the block is armed or pulsing |
| done | output | 1 | One-cycle flag when a pulse finishes |

## Verification
A corrupted length register or down-counter shows up as a SYNC width that differs from the expected cycle count. This mismatch is visible at the falling edge of `sync_out`, between 1 ms and a few ms after the PPS edge. A stuck armed state shows up within three cycles of a PPS edge: either an unwanted SYNC rise while `busy` was idle, or a missing rise while `busy` was high. A lost clear shows up on the very next edge as `busy` or `sync_out` remaining high.

// File: rtl/pps_sync_pkg.sv
package pps_sync_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_PULSE = 2'd2
  } sync_state_e;

endpackage

// File: rtl/pps_bit_sync.sv
module pps_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign d_sync = chain[LAST];
endmodule

// File: rtl/pps_rise_detect.sv
module pps_rise_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;
endmodule

// File: rtl/pps_len_select.sv
module pps_len_select #(
  parameter int              LEN_W   = 24,
  parameter logic [LEN_W-1:0] DEF_LEN = '0,
  parameter logic [LEN_W-1:0] MIN_LEN = '0
) (
  input  logic [LEN_W-1:0] req_len,
  output logic [LEN_W-1:0] eff_len
);
  always_comb begin
    if (req_len == '0)          eff_len = DEF_LEN;
    else if (req_len < MIN_LEN) eff_len = MIN_LEN;
    else                        eff_len = req_len;
  end
endmodule

// File: rtl/pps_pulse_fsm.sv
module pps_pulse_fsm
  import pps_sync_pkg::*;
#(
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             arm_edge,
  input  logic             pps_edge,
  input  logic [LEN_W-1:0] len_in,
  output logic             sync_q,
  output logic             busy,
  output logic             done_q
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  sync_state_e      st;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      len_q  <= '0;
      cnt    <= '0;
      sync_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (clr) begin
        st     <= ST_IDLE;
        cnt    <= '0;
        sync_q <= 1'b0;
      end else begin
        unique case (st)
          ST_IDLE: begin
            if (arm_edge) begin
              len_q <= len_in;
              st    <= ST_ARMED;
            end
          end
          ST_ARMED: begin
            if (pps_edge) begin
              st     <= ST_PULSE;
              sync_q <= 1'b1;
              cnt    <= len_q - ONE;
            end
          end
          ST_PULSE: begin
            if (cnt == '0) begin
              st     <= ST_IDLE;
              sync_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              cnt <= cnt - ONE;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy = (st != ST_IDLE);
endmodule

// File: rtl/pps_sync_gen.sv
module pps_sync_gen #(
  parameter int CLK_HZ      = 200_000_000,
  parameter int DEF_US      = 2000,
  parameter int MIN_US      = 1000,
  parameter int LEN_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_clr,
  input  logic             trig,
  input  logic             pps_async,
  input  logic [LEN_W-1:0] pulse_len,
  output logic             sync_out,
  output logic             busy,
  output logic             done
);
  localparam longint DEF_CYC = longint'(CLK_HZ) * longint'(DEF_US) / longint'(1000000);
  localparam longint MIN_CYC = longint'(CLK_HZ) * longint'(MIN_US) / longint'(1000000);
  localparam logic [LEN_W-1:0] DEF_LEN = DEF_CYC[LEN_W-1:0];
  localparam logic [LEN_W-1:0] MIN_LEN = MIN_CYC[LEN_W-1:0];

  logic             pps_s;
  logic             pps_rise;
  logic             trig_rise;
  logic [LEN_W-1:0] eff_len;

  pps_bit_sync #(.STAGES(SYNC_STAGES)) u_pps_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pps_async),
    .d_sync  (pps_s)
  );

  pps_rise_detect u_pps_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (pps_s),
    .rise  (pps_rise)
  );

  pps_rise_detect u_trig_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (trig),
    .rise  (trig_rise)
  );

  pps_len_select #(
    .LEN_W   (LEN_W),
    .DEF_LEN (DEF_LEN),
    .MIN_LEN (MIN_LEN)
  ) u_len (
    .req_len (pulse_len),
    .eff_len (eff_len)
  );

  pps_pulse_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (cnt_clr),
    .arm_edge (trig_rise),
    .pps_edge (pps_rise),
    .len_in   (eff_len),
    .sync_q   (sync_out),
    .busy     (busy),
    .done_q   (done)
  );
endmodule

// File: rtl/pps_sync_gen_chk.sv
module pps_sync_gen_chk #(
  parameter int MIN_CYC = 1
) (
  input logic clk,
  input logic rst_n,
  input logic cnt_clr,
  input logic trig,
  input logic sync_out,
  input logic busy,
  input logic done
);
  int unsigned hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hi_run <= 0;
    else if (sync_out) hi_run <= hi_run + 1;
    else               hi_run <= 0;
  end

  // R1
  idle_sync_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sync_out);

  // R2
  arm_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(trig) && !busy && !cnt_clr) |=> busy);

  // R3
  rise_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_out) |-> $past(busy));

  // R5
  min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (hi_run >= MIN_CYC));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!sync_out && $past(sync_out)));

  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (!busy && !sync_out && !done));

  // R11
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind pps_sync_gen pps_sync_gen_chk #(.MIN_CYC(int'(MIN_CYC))) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cnt_clr  (cnt_clr),
  .trig     (trig),
  .sync_out (sync_out),
  .busy     (busy),
  .done     (done)
);

// File: tb/pps_sync_gen_test.sv
module pps_sync_gen_test;
  localparam int CLK_HZ = 1_000_000;
  localparam int DEF_US = 2000;
  localparam int MIN_US = 1000;
  localparam int LEN_W  = 16;
  localparam int DEF_C  = 2000;
  localparam int MIN_C  = 1000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cnt_clr = 1'b0;
  logic             trig = 1'b0;
  logic             pps_async = 1'b0;
  logic [LEN_W-1:0] pulse_len = '0;
  logic             sync_out, busy, done;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pps_sync_gen #(
    .CLK_HZ(CLK_HZ), .DEF_US(DEF_US), .MIN_US(MIN_US), .LEN_W(LEN_W), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .trig(trig), .pps_async(pps_async),
    .pulse_len(pulse_len), .sync_out(sync_out), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int l);
    if (l == 0) return DEF_C;
    if (l < MIN_C) return MIN_C;
    return l;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pps_blip();
    pps_async = 1'b1;
    repeat (5) tick();
    pps_async = 1'b0;
    repeat (4) tick();
  endtask

  task automatic run_pulse(input int len, input int wait_c, input bit spam,
                           input bit hold_trig, input bit chg_len);
    int  width;
    int  early;
    int  lost_busy;
    string tag;
    tag = (len == 0) ? "R4" : ((len < MIN_C) ? "R5" : "R6");
    pulse_len = LEN_W'(len);
    trig = 1'b1;
    tick();
    chk(busy == 1'b1, "R2 arm on trigger edge", busy, 1);
    if (!hold_trig) trig = 1'b0;
    early = 0;
    for (int i = 0; i < wait_c; i++) begin
      tick();
      if (sync_out) early++;
    end
    chk(early == 0, "R3 no sync before pps", early, 0);
    pps_async = 1'b1;
    if (chg_len) pulse_len = LEN_W'($urandom_range(1, 3000));
    tick();
    tick();
    chk(sync_out == 1'b0, "R3 sync low two edges after pps", sync_out, 0);
    tick();
    chk(sync_out == 1'b1, "R3 sync high on third edge", sync_out, 1);
    width = 1;
    lost_busy = 0;
    for (int k = 0; k < 70000; k++) begin
      tick();
      if (k == 5) pps_async = 1'b0;
      if (spam) trig = 1'($urandom_range(0, 1));
      if (!sync_out) break;
      width++;
      if (!busy) lost_busy++;
    end
    chk(width == exp_len(len), {tag, " pulse width"}, width, exp_len(len));
    chk(lost_busy == 0, "R11 busy through pulse", lost_busy, 0);
    chk(done == 1'b1, "R8 done at fall", done, 1);
    chk(busy == 1'b0, "R11 busy low at done", busy, 0);
    if (!hold_trig) trig = 1'b0;
    tick();
    chk(done == 1'b0, "R8 done one cycle", done, 0);
    pps_blip();
    chk(sync_out == 1'b0 && busy == 1'b0,
        hold_trig ? "R2 held trigger no rearm" : "R7 no rearm after pulse",
        {30'd0, sync_out, busy}, 0);
    trig = 1'b0;
    tick();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_chk, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int mism;
    void'($urandom(32'h51c0));
    repeat (3) tick();
    chk({sync_out, busy, done} == 3'b000, "R1 outputs low in reset", {sync_out, busy, done}, 0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk({sync_out, busy, done} == 3'b000, "R1 idle after reset", {sync_out, busy, done}, 0);

    // R10: PPS while idle
    mism = 0;
    pps_async = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tick();
      if (sync_out || busy || done) mism++;
    end
    pps_async = 1'b0;
    repeat (4) tick();
    chk(mism == 0, "R10 pps ignored while idle", mism, 0);

    // directed lengths
    run_pulse(0, 3, 0, 0, 0);
    run_pulse(1, 0, 0, 0, 0);
    run_pulse(999, 7, 0, 0, 0);
    run_pulse(1000, 2, 0, 0, 0);
    run_pulse(1001, 1, 1, 0, 1);
    run_pulse(1200, 4, 0, 1, 0);

    // R9: clear while armed
    pulse_len = '0;
    trig = 1'b1;
    tick();
    trig = 1'b0;
    repeat (3) tick();
    cnt_clr = 1'b1;
    tick();
    cnt_clr = 1'b0;
    chk(busy == 1'b0, "R9 clear drops armed", busy, 0);
    pps_blip();
    chk(sync_out == 1'b0, "R9 no pulse after clear", sync_out, 0);

    // R9: clear during pulse
    trig = 1'b1;
    tick();
    trig = 1'b0;
    pps_async = 1'b1;
    repeat (3) tick();
    pps_async = 1'b0;
    chk(sync_out == 1'b1, "R9 setup pulse running", sync_out, 1);
    repeat (20) tick();
    cnt_clr = 1'b1;
    tick();
    chk({sync_out, busy, done} == 3'b000, "R9 clear aborts pulse", {sync_out, busy, done}, 0);
    cnt_clr = 1'b0;
    tick();
    chk(done == 1'b0, "R9 no done after abort", done, 0);

    // R9: trigger edge during clear is discarded
    cnt_clr = 1'b1;
    tick();
    trig = 1'b1;
    repeat (2) tick();
    cnt_clr = 1'b0;
    tick();
    chk(busy == 1'b0, "R9 trigger during clear ignored", busy, 0);
    pps_blip();
    chk(sync_out == 1'b0, "R9 no pulse from cleared trigger", sync_out, 0);
    trig = 1'b0;
    repeat (2) tick();

    // random mix
    for (int it = 0; it < 12; it++) begin
      int sel;
      int len;
      sel = $urandom_range(0, 3);
      case (sel)
        0: len = 0;
        1: len = $urandom_range(1, MIN_C - 1);
        2: len = $urandom_range(MIN_C, MIN_C + 600);
        default: len = MIN_C;
      endcase
      run_pulse(len, $urandom_range(0, 40), 1'($urandom_range(0, 1)), 1'b0,
                1'($urandom_range(0, 1)));
      repeat ($urandom_range(1, 5)) tick();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule